// File: doc/BRIEF.md
# External Interrupt Line Multiplexer

This block sits between the general-purpose pin banks of a chip and its external interrupt controller. It takes the level of every pin of nine 16-pin ports and produces sixteen interrupt-line levels. Line k is always fed from pin k of exactly one port. Which port that is comes from a 4-bit source field that belongs to the line. The interrupt controller downstream handles edge detection, masking and pending state.

Software programs the source fields over a small 32-bit register bus with a 0x400-byte window. Four selector registers hold the sixteen fields, four fields per register. The window also holds a compensation-control word, which is plain storage. Two further configuration words, for memory remapping and peripheral mode, are fixed at zero and ignore writes. Line outputs follow the pin levels with no register in the path. A new source selection applies from the clock edge that accepts the write.

Top module: `extline_router`

## Requirements
- R1: After reset, every register in the window reads 0x00000000 and each line k carries pin k of port 0.
- R2: The flat pin input index for port p, pin i is p*16+i. Line k outputs pin_lvl[p*16+k], where p is the value of line k's source field and 0 <= p <= 8.
- R3: Line k's source field is in the selector register at byte offset 0x08+4*(k/4), at bits [4*(k%4)+3 : 4*(k%4)].
- R4: A write to a selector register stores only wdata[15:0]. Bits 31:16 of that register always read as zero.
- R5: A source field value from 9 to 15 drives its line low, whatever the pin levels are.
- R6: In the cycle where a selector write is presented, the line still uses the old source. From the next cycle on it uses the new source.
- R7: Writes to offset 0x00 (remap) and 0x04 (peripheral mode) have no effect. Both offsets read zero, and the line outputs do not change.
- R8: The compensation word at offset 0x20 stores all 32 bits of a write and reads them back.
- R9: A read from any offset not listed in R3, R7 or R8 returns zero, and this includes offsets not aligned to a word. A write to such an offset changes no register.
- R10: rdata carries the addressed value in the cycle after rd_en is sampled high. In a cycle after rd_en was low, rdata is zero.
- R11: When a read and a write target the same register in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | 144 | Pin levels; port p, pin i at index p*16+i |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| line_out | output | 16 | Interrupt line levels |

## Verification
The hardest case to reach is the single cycle in which a new source field has been presented but not yet taken. The old and new sources must then be seen to disagree at the line output. The stimulus sets up that disagreement first: the old port's pin is low and the new port's pin is high. It then samples the line just after the write is driven and again one cycle later. The same approach is used for the combined read-and-write cycle. In that test the stored and incoming compensation values differ in every nibble, so the returned value shows which of the two the read took.

// File: rtl/extline_pkg.sv
package extline_pkg;
  // Register offsets within the window (byte addresses, word aligned)
  localparam int unsigned OFF_REMAP = 32'h00;
  localparam int unsigned OFF_MODE  = 32'h04;
  localparam int unsigned OFF_SEL0  = 32'h08;
  localparam int unsigned OFF_COMP  = 32'h20;
  localparam int unsigned WIN_BYTES = 32'h400;
endpackage

// File: rtl/extline_regfile.sv
module extline_regfile
  import extline_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int SEL_REGS = 4,
  parameter int SEL_KEEP = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [SEL_REGS*SEL_KEEP-1:0] sel_flat
);
  localparam int HI_W = DATA_W - SEL_KEEP;

  logic [SEL_KEEP-1:0] sel_q [SEL_REGS];
  logic [DATA_W-1:0]   comp_q;
  logic [SEL_REGS-1:0] sel_hit;
  logic                comp_hit;
  logic                cfg_hit;
  logic [DATA_W-1:0]   rd_val;

  assign comp_hit = (addr == ADDR_W'(OFF_COMP));
  assign cfg_hit  = (addr == ADDR_W'(OFF_REMAP)) || (addr == ADDR_W'(OFF_MODE));

  genvar gi;
  generate
    for (gi = 0; gi < SEL_REGS; gi++) begin : g_sel
      assign sel_hit[gi] = (addr == ADDR_W'(OFF_SEL0 + 4 * gi));

      always_ff @(posedge clk) begin
        if (rst)
          sel_q[gi] <= '0;
        else if (wr_en && sel_hit[gi])
          sel_q[gi] <= wdata[SEL_KEEP-1:0];
      end

      assign sel_flat[gi*SEL_KEEP +: SEL_KEEP] = sel_q[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      comp_q <= '0;
    else if (wr_en && comp_hit)
      comp_q <= wdata;
  end

  // Remap and mode words read as constant zero; unmapped offsets too.
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < SEL_REGS; i++)
      if (sel_hit[i]) rd_val = {{HI_W{1'b0}}, sel_q[i]};
    if (comp_hit) rd_val = comp_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= rd_en ? rd_val : '0;
  end

  // R10: idle bus gives zero read data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);

  // R4: upper half of a selector read is zero
  p_sel_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (|sel_hit)) |=> rdata[DATA_W-1:SEL_KEEP] == '0);

  // R7: remap and mode words read zero
  p_cfg_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cfg_hit) |=> rdata == '0);

  // R9: unmapped read returns zero
  p_unmapped_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(|sel_hit) && !comp_hit) |=> rdata == '0);

  // R8: write then immediate read of compensation returns the written word
  p_comp_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && comp_hit) ##1 (rd_en && comp_hit && !wr_en)
      |=> rdata == $past(wdata, 2));
endmodule

// File: rtl/extline_select.sv
module extline_select #(
  parameter int NUM_PORTS = 9,
  parameter int PINS      = 16,
  parameter int SEL_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PORTS*PINS-1:0] pins,
  input  logic [PINS*SEL_W-1:0]     sel_flat,
  output logic [PINS-1:0]           lines
);
  localparam int CODES = 1 << SEL_W;

  genvar gk, gp;
  generate
    for (gk = 0; gk < PINS; gk++) begin : g_line
      logic [CODES-1:0] column;
      logic [SEL_W-1:0] src;

      assign src = sel_flat[gk*SEL_W +: SEL_W];

      // Codes beyond the last port are tied low in the column.
      for (gp = 0; gp < CODES; gp++) begin : g_port
        if (gp < NUM_PORTS) begin : g_real
          assign column[gp] = pins[gp*PINS + gk];
        end else begin : g_none
          assign column[gp] = 1'b0;
        end
      end

      assign lines[gk] = column[src];

      // R5: a code naming no port drives the line low
      p_bad_code_low_r5: assert property (@(posedge clk) disable iff (rst)
        (src >= SEL_W'(NUM_PORTS)) |-> !lines[gk]);
    end
  endgenerate
endmodule

// File: rtl/extline_router.sv
module extline_router
  import extline_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int PINS      = 16,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int SEL_KEEP  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PORTS*PINS-1:0] pin_lvl,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [PINS-1:0]           line_out
);
  localparam int SEL_REGS = (PINS * SEL_W) / SEL_KEEP;

  logic [PINS*SEL_W-1:0] sel_flat;

  extline_regfile #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEL_REGS(SEL_REGS),
    .SEL_KEEP(SEL_KEEP)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .sel_flat(sel_flat)
  );

  extline_select #(
    .NUM_PORTS(NUM_PORTS),
    .PINS     (PINS),
    .SEL_W    (SEL_W)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .pins    (pin_lvl),
    .sel_flat(sel_flat),
    .lines   (line_out)
  );

  // R2/R6: after a valid source write for line 0, line 0 follows that port
  p_route_after_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_SEL0) && wdata[SEL_W-1:0] < SEL_W'(NUM_PORTS))
      |=> line_out[0] == pin_lvl[$past(wdata[SEL_W-1:0]) * PINS]);
endmodule

// File: tb/extline_router_tb.sv
module extline_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 9;
  localparam int NPIN = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NP*NPIN-1:0] pin_lvl = '0;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [9:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [15:0]    line_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extline_router u_dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .line_out(line_out)
  );

  // Entry: {source code, line, port whose pin is driven high, expected line}
  localparam logic [12:0] VEC [8] = '{
    {4'd0,  4'd0,  4'd0, 1'b1},
    {4'd3,  4'd5,  4'd3, 1'b1},
    {4'd8,  4'd15, 4'd8, 1'b1},
    {4'd2,  4'd7,  4'd3, 1'b0},
    {4'd5,  4'd10, 4'd5, 1'b1},
    {4'd9,  4'd4,  4'd0, 1'b0},
    {4'd15, 4'd12, 4'd8, 1'b0},
    {4'd1,  4'd1,  4'd1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register and routing from port 0
    begin
      logic [9:0] offs [7] = '{10'h00, 10'h04, 10'h08, 10'h0C, 10'h10, 10'h14, 10'h20};
      for (int i = 0; i < 7; i++) begin
        bus_rd(offs[i], d);
        chk("R1 reset reg", d, 32'h0);
      end
    end
    pin_lvl = '0;
    pin_lvl[15:0] = 16'hFFFF;
    #1 chk("R1 port0 routed", {16'h0, line_out}, 32'h0000FFFF);

    // R2/R3/R5: table walk
    for (int v = 0; v < 8; v++) begin
      logic [3:0] s, ln, pt;
      logic       ex;
      {s, ln, pt, ex} = VEC[v];
      pin_lvl = '0;
      pin_lvl[pt*NPIN + ln] = 1'b1;
      bus_wr(10'h08 + 10'(4 * (ln / 4)), 32'(s) << (4 * (ln % 4)));
      #1 chk((s > 8) ? "R5 bad code" : "R2 route", {31'h0, line_out[ln]}, {31'h0, ex});
    end

    // R3: four fields of the second selector register
    pin_lvl = '0;
    pin_lvl[0*16 + 4] = 1'b1;
    pin_lvl[1*16 + 5] = 1'b1;
    pin_lvl[2*16 + 6] = 1'b1;
    pin_lvl[3*16 + 7] = 1'b1;
    bus_wr(10'h0C, 32'h0000_3210);
    #1 chk("R3 packed fields", {28'h0, line_out[7:4]}, 32'hF);
    pin_lvl[1*16 + 5] = 1'b0;
    #1 chk("R3 field isolation", {28'h0, line_out[7:4]}, 32'hD);

    // R4: upper bits dropped
    bus_wr(10'h10, 32'hFFFF_ABCD);
    bus_rd(10'h10, d);
    chk("R4 mask", d, 32'h0000_ABCD);

    // R10: read data returns to zero after the read
    @(negedge clk);
    chk("R10 idle zero", rdata, 32'h0);

    // R6: old source in the write cycle, new one after
    bus_wr(10'h08, 32'h0);
    pin_lvl = '0;
    pin_lvl[2*16 + 0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 10'h08; wdata = 32'h2;
    #1 chk("R6 old source", {31'h0, line_out[0]}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R6 new source", {31'h0, line_out[0]}, 32'h1);

    // R7: remap and mode ignore writes
    bus_wr(10'h00, 32'hFFFF_FFFF);
    bus_wr(10'h04, 32'hFFFF_FFFF);
    #1 chk("R7 lines unchanged", {31'h0, line_out[0]}, 32'h1);
    bus_rd(10'h00, d);
    chk("R7 remap zero", d, 32'h0);
    bus_rd(10'h04, d);
    chk("R7 mode zero", d, 32'h0);

    // R8: compensation full width
    bus_wr(10'h20, 32'hDEAD_BEEF);
    bus_rd(10'h20, d);
    chk("R8 comp readback", d, 32'hDEAD_BEEF);

    // R9: unmapped and misaligned accesses
    bus_wr(10'h30, 32'h1234_5678);
    bus_rd(10'h30, d);
    chk("R9 unmapped read", d, 32'h0);
    bus_wr(10'h09, 32'h0000_5555);
    bus_rd(10'h08, d);
    chk("R9 misaligned write", d, 32'h2);
    bus_rd(10'h22, d);
    chk("R9 misaligned read", d, 32'h0);

    // R11: simultaneous read and write
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 10'h20; wdata = 32'h2152_4110;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 old value", rdata, 32'hDEAD_BEEF);
    bus_rd(10'h20, d);
    chk("R11 new value", d, 32'h2152_4110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule